// File: doc/BRIEF.md
# Dual-Phase Serial Audio Framer

This block moves PCM sample words between a parallel valid/ready interface and a pair of serial data lines. A frame begins on a frame-sync pulse. After it, the transmit side shifts words out most significant bit first, one bit for every bit-clock enable. The receive side collects the same bit slots from its input line and presents each finished word on a parallel output. An external generator supplies the frame-sync pulse and the bit-clock enable.

A frame holds one phase or two. Each phase has its own word count and its own word-length code. Stereo I2S or left-justified audio uses two phases of one word each. Multi-channel DSP-style audio uses a single phase with one word per channel. The first data bit can start in the same bit slot as frame sync or one slot later. Three sticky flags record errors: a transmit word that was missing, a receive word that was never taken, and a frame sync that cut a frame short. The flags clear only on reset.

Top module: `serial_audio_framer`

## Requirements
- R1: After reset, `sdo`, `tx_ready`, `rx_valid`, `underrun`, `overrun` and `frame_err` are all 0.
- R2: The word-length code of a phase sets the bits per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 and 7 give 32. The transmitted bits are the top bits of `tx_data`, sent bit 31 first.
- R3: A phase carries its 7-bit word-count field plus one words.
- R4: With `dual_phase` high, phase 1 follows phase 0 straight away, using its own count and length. With `dual_phase` low, the frame ends after phase 0.
- R5: With `late_start` low, the first data bit is driven in the bit slot that samples frame sync. With `late_start` high, it is driven in the slot after that.
- R6: `sdo` changes only on cycles with `bit_en` high. Outside a frame it is 0.
- R7: Each received word appears on `rx_data` with its bits in the most significant positions and the lower bits 0. `rx_valid` stays high until `rx_ready` accepts the word.
- R8: If no transmit word is offered when a word starts, that word is sent as zeros and `underrun` is set.
- R9: If a received word completes while the previous one is still unaccepted, the new word replaces it and `overrun` is set.
- R10: A frame sync that arrives before the last bit of the frame has been driven restarts the frame from phase 0 and sets `frame_err`. The partly received word is dropped. A frame sync in the slot right after the last bit is not an error.
- R11: `tx_ready` is high only in a bit-enable cycle that starts a word. Exactly one transmit word is taken per word slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One bit slot per high cycle |
| fsync | input | 1 | Frame start, sampled when bit_en is high |
| dual_phase | input | 1 | Enables the second phase |
| late_start | input | 1 | Adds a one-bit data delay after frame sync |
| p0_len | input | 3 | Phase 0 word-length code |
| p0_words | input | 7 | Phase 0 word count minus one |
| p1_len | input | 3 | Phase 1 word-length code |
| p1_words | input | 7 | Phase 1 word count minus one |
| tx_data | input | 32 | Transmit word, left-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_data | output | 32 | Received word, left-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word accepted |
| underrun | output | 1 | Sticky: transmit word was missing |
| overrun | output | 1 | Sticky: received word was overwritten |
| frame_err | output | 1 | Sticky: frame sync came early |

## Verification
The bench loops `sdo` back to `sdi` and checks that every received word equals the transmitted word cut to its phase's length. A design that mis-decoded a length code or lost count of words would return shifted or missing words. It checks single-bit patterns in the first slots after frame sync, which exposes a data delay that is off by one. It also runs back-to-back frames, where a design that tested frame completion one slot late would raise a false frame error. An aborted frame must deliver only the words that finished before the restart. The bench starves the transmit side and stalls the receive side to confirm zero fill, overwrite and the sticky flags.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = $clog2(WORD_W + 1);

  // word-length code to bits per word; unused codes give a full word
  function automatic logic [LEN_W-1:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    wlen_bits = LEN_W'(8);
      3'd1:    wlen_bits = LEN_W'(12);
      3'd2:    wlen_bits = LEN_W'(16);
      3'd3:    wlen_bits = LEN_W'(20);
      3'd4:    wlen_bits = LEN_W'(24);
      default: wlen_bits = LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/saf_sequencer.sv
module saf_sequencer #(
  parameter int unsigned WCNT_W = 7,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic              dual_phase,
  input  logic              late_start,
  input  logic [LEN_W-1:0]  len0,
  input  logic [LEN_W-1:0]  len1,
  input  logic [WCNT_W-1:0] cnt0,
  input  logic [WCNT_W-1:0] cnt1,
  output logic              emit_o,
  output logic              first_o,
  output logic              last_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              ferr_o
);
  logic              act_q, act_n, pend_q, pend_n, ph_q, ph_n;
  logic [WCNT_W-1:0] wd_q, wd_n;
  logic [LEN_W-1:0]  bt_q, bt_n;
  logic [LEN_W-1:0]  len_cur, len_nxt;
  logic [WCNT_W-1:0] cnt_cur;
  logic              word_end, phase_end, at_final;

  always_comb begin
    len_cur   = ph_q ? len1 : len0;
    cnt_cur   = ph_q ? cnt1 : cnt0;
    word_end  = (bt_q == len_cur - LEN_W'(1));
    phase_end = word_end && (wd_q == cnt_cur);
    at_final  = act_q && !pend_q && phase_end && (ph_q || !dual_phase);

    act_n  = act_q;
    pend_n = pend_q;
    ph_n   = ph_q;
    wd_n   = wd_q;
    bt_n   = bt_q;
    emit_o = 1'b0;
    ferr_o = 1'b0;

    if (bit_en && fsync) begin
      ferr_o = act_q && !at_final;
      act_n  = 1'b1;
      pend_n = late_start;
      ph_n   = 1'b0;
      wd_n   = '0;
      bt_n   = '0;
      emit_o = !late_start;
    end else if (bit_en && act_q) begin
      if (pend_q) begin
        pend_n = 1'b0;
        emit_o = 1'b1;
      end else if (at_final) begin
        act_n = 1'b0;
      end else begin
        emit_o = 1'b1;
        if (!word_end) begin
          bt_n = bt_q + LEN_W'(1);
        end else begin
          bt_n = '0;
          if (!phase_end) begin
            wd_n = wd_q + WCNT_W'(1);
          end else begin
            ph_n = 1'b1;
            wd_n = '0;
          end
        end
      end
    end

    len_nxt = ph_n ? len1 : len0;
    len_o   = len_nxt;
    first_o = emit_o && (bt_n == '0);
    last_o  = emit_o && (bt_n == len_nxt - LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      ph_q   <= 1'b0;
      wd_q   <= '0;
      bt_q   <= '0;
    end else if (bit_en) begin
      act_q  <= act_n;
      pend_q <= pend_n;
      ph_q   <= ph_n;
      wd_q   <= wd_n;
      bt_q   <= bt_n;
    end
  end
endmodule

// File: rtl/saf_tx_shifter.sv
module saf_tx_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              emit,
  input  logic              first,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sdo,
  output logic              urun_set
);
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              sdo_q, sdo_n;

  always_comb begin
    tx_ready = emit && first;
    urun_set = emit && first && !tx_valid;
    sh_n     = sh_q;
    sdo_n    = sdo_q;
    if (emit && first) begin
      sdo_n = tx_valid && tx_data[WORD_W-1];
      sh_n  = tx_valid ? {tx_data[WORD_W-2:0], 1'b0} : '0;
    end else if (emit) begin
      sdo_n = sh_q[WORD_W-1];
      sh_n  = {sh_q[WORD_W-2:0], 1'b0};
    end else begin
      sdo_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (bit_en) begin
      sh_q  <= sh_n;
      sdo_q <= sdo_n;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/saf_rx_shifter.sv
module saf_rx_shifter #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sdi,
  input  logic              emit,
  input  logic              first,
  input  logic              last,
  input  logic [LEN_W-1:0]  len,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              orun_set
);
  logic              sv_q, sf_q, sl_q;
  logic [LEN_W-1:0]  sln_q, shamt;
  logic [WORD_W-1:0] acc_q, acc_n, dat_q, dat_n;
  logic              val_q, val_n, done;

  always_comb begin
    acc_n    = sf_q ? {{(WORD_W-1){1'b0}}, sdi} : {acc_q[WORD_W-2:0], sdi};
    done     = bit_en && sv_q && sl_q;
    shamt    = LEN_W'(WORD_W) - sln_q;
    orun_set = done && val_q && !rx_ready;
    dat_n    = done ? (acc_n << shamt) : dat_q;
    if (done)
      val_n = 1'b1;
    else if (val_q && rx_ready)
      val_n = 1'b0;
    else
      val_n = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q  <= 1'b0;
      sf_q  <= 1'b0;
      sl_q  <= 1'b0;
      sln_q <= '0;
      acc_q <= '0;
    end else if (bit_en) begin
      sv_q  <= emit;
      sf_q  <= first;
      sl_q  <= last;
      sln_q <= len;
      if (sv_q) acc_q <= acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      val_q <= 1'b0;
    end else begin
      dat_q <= dat_n;
      val_q <= val_n;
    end
  end

  assign rx_data  = dat_q;
  assign rx_valid = val_q;
endmodule

// File: rtl/serial_audio_framer.sv
module serial_audio_framer #(
  parameter int unsigned WCNT_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        fsync,
  input  logic        dual_phase,
  input  logic        late_start,
  input  logic [2:0]  p0_len,
  input  logic [6:0]  p0_words,
  input  logic [2:0]  p1_len,
  input  logic [6:0]  p1_words,
  input  logic [31:0] tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        sdo,
  input  logic        sdi,
  output logic [31:0] rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        underrun,
  output logic        overrun,
  output logic        frame_err
);
  import saf_pkg::*;

  logic             emit, first, last, ferr, urun_set, orun_set;
  logic [LEN_W-1:0] cur_len;
  logic             urun_q, orun_q, ferr_q;

  saf_sequencer #(.WCNT_W(WCNT_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .dual_phase(dual_phase), .late_start(late_start),
    .len0(wlen_bits(p0_len)), .len1(wlen_bits(p1_len)),
    .cnt0(WCNT_W'(p0_words)), .cnt1(WCNT_W'(p1_words)),
    .emit_o(emit), .first_o(first), .last_o(last), .len_o(cur_len),
    .ferr_o(ferr)
  );

  saf_tx_shifter #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .emit(emit), .first(first),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sdo(sdo), .urun_set(urun_set)
  );

  saf_rx_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdi(sdi), .emit(emit),
    .first(first), .last(last), .len(cur_len), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .orun_set(orun_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun_q <= 1'b0;
      orun_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (urun_set) urun_q <= 1'b1;
      if (orun_set) orun_q <= 1'b1;
      if (ferr)     ferr_q <= 1'b1;
    end
  end

  assign underrun  = urun_q;
  assign overrun   = orun_q;
  assign frame_err = ferr_q;
endmodule

// File: rtl/saf_checker.sv
module saf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_en,
  input logic        fsync,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        sdo,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_data,
  input logic        underrun,
  input logic        overrun,
  input logic        frame_err
);
  p_ready_on_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bit_en);

  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sdo));

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  p_rx_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !bit_en |=> $stable(rx_data));

  p_urun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(bit_en && !tx_valid));

  p_orun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid && !rx_ready));

  p_ferr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(bit_en && fsync));

  p_ferr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
endmodule

bind serial_audio_framer saf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .sdo(sdo),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .underrun(underrun), .overrun(overrun), .frame_err(frame_err)
);

// File: tb/serial_audio_framer_bench.sv
module serial_audio_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en, fsync, dual_phase, late_start;
  logic [2:0]  p0_len, p1_len;
  logic [6:0]  p0_words, p1_words;
  logic [31:0] tx_data;
  logic        tx_valid, tx_ready, sdo, sdi;
  logic [31:0] rx_data;
  logic        rx_valid, rx_ready;
  logic        underrun, overrun, frame_err;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic        last_sdo;

  always #2.5 clk = ~clk;
  assign sdi = sdo;

  serial_audio_framer u_serial_audio_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .dual_phase(dual_phase), .late_start(late_start),
    .p0_len(p0_len), .p0_words(p0_words), .p1_len(p1_len), .p1_words(p1_words),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sdo(sdo), .sdi(sdi), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .underrun(underrun), .overrun(overrun),
    .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_top(input logic [31:0] w, input int code);
    int bits;
    case (code)
      0: bits = 8;  1: bits = 12; 2: bits = 16;
      3: bits = 20; 4: bits = 24; default: bits = 32;
    endcase
    keep_top = w & ~(32'hFFFF_FFFF >> bits);
  endfunction

  // driver side of the transmit handshake
  always @(negedge clk) begin
    tx_valid = (txq.size() > 0);
    tx_data  = (txq.size() > 0) ? txq[0] : 32'h0;
  end
  always @(posedge clk) if (tx_valid && tx_ready) void'(txq.pop_front());

  // scoreboard monitor on the receive handshake
  always @(posedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (rxq.size() == 0) begin
        check(1'b0, "R7 unexpected word", rx_data, 32'h0);
      end else begin
        logic [31:0] e;
        e = rxq.pop_front();
        check(rx_data == e, "R2 R3 R7 received word", rx_data, e);
      end
    end
  end

  task automatic slot(input bit fs);
    @(negedge clk); bit_en = 1'b1; fsync = fs;
    @(negedge clk); bit_en = 1'b0; fsync = 1'b0;
    last_sdo = sdo;
  endtask

  task automatic run_frame(input int bits, input bit late);
    slot(1'b1);
    repeat (bits - 1 + int'(late)) slot(1'b0);
    repeat (2) slot(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; rx_ready = 1'b1;
    txq.delete(); rxq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input bit dp, input bit late, input int l0, input int c0,
                     input int l1, input int c1);
    dual_phase = dp; late_start = late;
    p0_len = 3'(l0); p0_words = 7'(c0); p1_len = 3'(l1); p1_words = 7'(c1);
  endtask

  task automatic end_test(input string req);
    repeat (3) @(negedge clk);
    check(rxq.size() == 0, req, 32'(rxq.size()), 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; rx_ready = 1'b1;
    cfg(0, 0, 2, 0, 2, 0);
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(sdo == 0 && tx_ready == 0 && rx_valid == 0, "R1 outputs", {sdo, tx_ready, rx_valid}, 0);
    check(underrun == 0 && overrun == 0 && frame_err == 0, "R1 flags",
          {underrun, overrun, frame_err}, 0);

    // R2 R3 R10: single phase 2x16 bits, two frames back to back
    cfg(0, 0, 2, 1, 0, 0);
    begin
      logic [31:0] w[4] = '{32'h1234_5678, 32'hCAFE_F00D, 32'h8001_7FFE, 32'h0F0F_A5A5};
      foreach (w[i]) begin txq.push_back(w[i]); rxq.push_back(keep_top(w[i], 2)); end
    end
    slot(1'b1); repeat (31) slot(1'b0);
    run_frame(32, 0);
    end_test("R3 words per frame");
    check(frame_err == 0, "R10 back-to-back is no error", frame_err, 0);
    check(underrun == 0, "R11 one word per slot", underrun, 0);

    // R4 R5: dual phase 16 + 32 bits, late start
    do_reset(); cfg(1, 1, 2, 0, 5, 0);
    txq.push_back(32'hABCD_1357); rxq.push_back(keep_top(32'hABCD_1357, 2));
    txq.push_back(32'h9876_5432); rxq.push_back(32'h9876_5432);
    run_frame(48, 1);
    end_test("R4 dual phase");

    // R2 R3: single phase 3x20 bits
    do_reset(); cfg(0, 0, 3, 2, 0, 0);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] w; w = 32'hF1E2_D3C4 ^ (32'h1111_1111 * i);
      txq.push_back(w); rxq.push_back(keep_top(w, 3));
    end
    run_frame(60, 0);
    end_test("R2 20-bit");

    // R2 R4: dual phase 2x8 bits then 1x24 bits
    do_reset(); cfg(1, 0, 0, 1, 4, 0);
    txq.push_back(32'hA5FF_FFFF); rxq.push_back(32'hA500_0000);
    txq.push_back(32'h3CFF_FFFF); rxq.push_back(32'h3C00_0000);
    txq.push_back(32'h7654_32FF); rxq.push_back(32'h7654_3200);
    run_frame(40, 0);
    end_test("R4 8+24 bits");

    // R5 R6: zero delay, first bit in the sync slot
    do_reset(); cfg(0, 0, 2, 0, 0, 0);
    txq.push_back(32'hA000_0000); rxq.push_back(32'hA000_0000);
    slot(1'b1); check(last_sdo == 1, "R5 delay0 slot0", last_sdo, 1);
    slot(1'b0); check(last_sdo == 0, "R5 delay0 slot1", last_sdo, 0);
    slot(1'b0); check(last_sdo == 1, "R5 delay0 slot2", last_sdo, 1);
    repeat (13) slot(1'b0);
    slot(1'b0); check(last_sdo == 0, "R6 idle after frame", last_sdo, 0);
    slot(1'b0);
    end_test("R5 delay0");

    // R5: one-bit delay
    do_reset(); cfg(0, 1, 2, 0, 0, 0);
    txq.push_back(32'h8000_0000); rxq.push_back(32'h8000_0000);
    slot(1'b1); check(last_sdo == 0, "R5 delay1 sync slot", last_sdo, 0);
    slot(1'b0); check(last_sdo == 1, "R5 delay1 first bit", last_sdo, 1);
    repeat (17) slot(1'b0);
    end_test("R5 delay1");

    // R8: no transmit word, 12-bit phase
    do_reset(); cfg(0, 0, 1, 0, 0, 0);
    rxq.push_back(32'h0);
    run_frame(12, 0);
    end_test("R8 zero word");
    check(underrun == 1, "R8 underrun flag", underrun, 1);

    // R9: receive side stalled over two words
    do_reset(); cfg(0, 0, 2, 1, 0, 0);
    rx_ready = 1'b0;
    txq.push_back(32'h1111_2222); txq.push_back(32'h3333_4444);
    run_frame(32, 0);
    check(rx_valid == 1, "R7 valid held", rx_valid, 1);
    check(overrun == 1, "R9 overrun flag", overrun, 1);
    rxq.push_back(32'h3333_0000);
    @(negedge clk); rx_ready = 1'b1;
    end_test("R9 newest word kept");

    // R10: early frame sync restarts
    do_reset(); cfg(0, 0, 2, 1, 0, 0);
    txq.push_back(32'hAAAA_0001); txq.push_back(32'hBBBB_0002); txq.push_back(32'hCCCC_0003);
    rxq.push_back(32'hAAAA_0000); rxq.push_back(32'hCCCC_0000); rxq.push_back(32'h0);
    slot(1'b1); repeat (19) slot(1'b0);
    check(frame_err == 0, "R10 no error before sync", frame_err, 0);
    run_frame(32, 0);
    check(frame_err == 1, "R10 early sync flagged", frame_err, 1);
    end_test("R10 restart content");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule